// File: doc/BRIEF.md
# Half-Duplex Inter-Frame Gap Deferral Timer

This block decides when a half-duplex Ethernet transmitter may start a frame. It measures the quiet time on the medium in bit-times, counting one step per bit-time tick. Carrier sense holds the count at zero. The count starts to climb once carrier goes away, and it stops at the configured gap length. When the gap is complete and the transmitter has a frame waiting, the permission output goes high.

The gap is split into two zones so that access to the medium stays fair. In the early zone, which runs from zero up to the blinder point, any carrier restarts the gap from zero. Past the blinder point, the station has committed to its deferral: carrier seen there is ignored and the count keeps running. Once the gap is complete, new carrier means a new frame is on the wire, and the count restarts.

Both thresholds are 5-bit fields in units of 4 bit-times. The block copies them into internal registers only while the port is disabled, and it holds them fixed while the port is enabled. Backoff, jam generation and the MAC datapath belong to other blocks. The request/permission pair is a plain level interface, not a data stream, so no back-pressure rules apply: the transmitter holds its request until it sees permission.

Top module: `gap_defer_timer`

## Requirements
- R1: After reset the gap length is 96 bit-times and the blinder point is 64 bit-times, the count is zero and `tx_ok` is 0. If the port stays enabled from reset, with no carrier and a tick every cycle, `tx_ok` rises on the 96th clock edge after reset is released.
- R2: While enabled, the gap is complete when the count equals 4 × the captured gap field. `tx_ok` is 1 exactly when the port is enabled, `tx_req` is 1 and the gap is complete.
- R3: A gap field value below 3 is treated as 3, which gives a gap of 12 bit-times.
- R4: Carrier sense seen on an edge while the count is below the blinder point (4 × the blinder field) sets the count to zero.
- R5: Carrier sense seen while the count is at or above the blinder point and below the gap length is ignored, and counting goes on.
- R6: Carrier sense seen while the gap is complete sets the count to zero, so a new full gap is required.
- R7: The count rises by one only on edges where `bit_tick` is 1. It never exceeds the gap length and stays there while the medium is quiet.
- R8: Both configuration fields are captured on every edge where `port_en` is 0. Changes to them while the port is enabled have no effect.
- R9: While `port_en` is 0, the count is held at zero and `tx_ok` is 0.
- R10: A blinder field value below 3 is treated as 3, which puts the blinder point at 12 bit-times.
- R11: `tx_ok` follows `tx_req` in the same cycle and is never 1 while `tx_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; configuration is captured while this is 0 |
| bit_tick | input | 1 | One-cycle pulse per bit-time |
| crs | input | 1 | Carrier sense from the medium |
| tx_req | input | 1 | Transmitter has a frame waiting |
| cfg_gap | input | 5 | Gap length in units of 4 bit-times |
| cfg_blind | input | 5 | Blinder point in units of 4 bit-times |
| tx_ok | output | 1 | Transmission may start |

## Verification
`tx_ok` is a combinational function of the registered count and the live `tx_req` and `port_en`. A change in request or enable shows up in the same cycle. A tick, a carrier event or a configuration capture affects `tx_ok` only after the next clock edge. The bench drives and samples 1 ns after each rising edge, and it compares against a behavioural model that updates on that same edge, so every check falls one edge after the stimulus that caused it. Directed checks with hand-counted edge numbers cover the blinder boundary (count one below and exactly at the point), gap completion, and the clamped minimum values.

// File: rtl/gap_defer_pkg.sv
package gap_defer_pkg;
  // Position of the running count relative to the two thresholds
  typedef enum logic [1:0] {
    ZONE_OFF    = 2'd0,  // port disabled
    ZONE_BLIND  = 2'd1,  // carrier restarts the gap
    ZONE_COMMIT = 2'd2,  // carrier ignored
    ZONE_DONE   = 2'd3   // gap complete
  } gap_zone_e;
endpackage

// File: rtl/gap_cfg_shadow.sv
module gap_cfg_shadow #(
  parameter int unsigned FIELD_W     = 5,
  parameter int unsigned STEP_SH     = 2,
  parameter int unsigned MIN_UNITS   = 3,
  parameter int unsigned RESET_UNITS = 24,
  localparam int unsigned BT_W       = FIELD_W + STEP_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] field,
  output logic [BT_W-1:0]    bit_times
);
  logic [FIELD_W-1:0] units;

  // values below the legal minimum are raised to it
  always_comb begin
    if (field < FIELD_W'(MIN_UNITS)) units = FIELD_W'(MIN_UNITS);
    else                             units = field;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bit_times <= BT_W'(RESET_UNITS) << STEP_SH;
    else if (load)  bit_times <= {units, {STEP_SH{1'b0}}};
  end
endmodule

// File: rtl/gap_counter.sv
module gap_counter
  import gap_defer_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             crs,
  input  logic [CNT_W-1:0] gap_bt,
  input  logic [CNT_W-1:0] blind_bt,
  output logic [CNT_W-1:0] cnt,
  output gap_zone_e        zone
);
  always_comb begin
    if (!en)                 zone = ZONE_OFF;
    else if (cnt == gap_bt)  zone = ZONE_DONE;
    else if (cnt < blind_bt) zone = ZONE_BLIND;
    else                     zone = ZONE_COMMIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      unique case (zone)
        ZONE_OFF:    cnt <= '0;
        ZONE_BLIND:  if (crs) cnt <= '0;
                     else if (tick) cnt <= cnt + CNT_W'(1);
        ZONE_COMMIT: if (tick) cnt <= cnt + CNT_W'(1);
        ZONE_DONE:   if (crs) cnt <= '0;
        default:     cnt <= '0;
      endcase
    end
  end

  // early carrier restarts the gap
  assert_early_carrier_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && crs && cnt < blind_bt && cnt != gap_bt) |=> (cnt == '0));

  // carrier past the blinder point does not disturb counting
  assert_late_carrier_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && crs && tick && cnt >= blind_bt && cnt < gap_bt) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // carrier on a completed gap forces a new deferral
  assert_done_carrier_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && crs && cnt == gap_bt) |=> (cnt == '0));

  // no tick and a quiet medium means no movement
  assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick && !crs && $past(en)) |=> $stable(cnt));

  // disabled port keeps the count cleared
  assert_disabled_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/gap_defer_timer.sv
module gap_defer_timer
  import gap_defer_pkg::*;
#(
  parameter int unsigned FIELD_W      = 5,
  parameter int unsigned STEP_SH      = 2,
  parameter int unsigned GAP_MIN      = 3,
  parameter int unsigned BLIND_MIN    = 3,
  parameter int unsigned GAP_RESET    = 24,
  parameter int unsigned BLIND_RESET  = 16,
  localparam int unsigned CNT_W       = FIELD_W + STEP_SH,
  localparam int unsigned N_FIELDS    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic               bit_tick,
  input  logic               crs,
  input  logic               tx_req,
  input  logic [FIELD_W-1:0] cfg_gap,
  input  logic [FIELD_W-1:0] cfg_blind,
  output logic               tx_ok
);
  localparam int unsigned MINS   [N_FIELDS] = '{GAP_MIN, BLIND_MIN};
  localparam int unsigned RESETS [N_FIELDS] = '{GAP_RESET, BLIND_RESET};

  logic [FIELD_W-1:0] fields [N_FIELDS];
  logic [CNT_W-1:0]   thr    [N_FIELDS];
  logic [CNT_W-1:0]   gap_bt, blind_bt, cnt;
  gap_zone_e          zone;

  assign fields[0] = cfg_gap;
  assign fields[1] = cfg_blind;

  // one shadow register per threshold, loaded only while disabled
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_shadow
    gap_cfg_shadow #(
      .FIELD_W(FIELD_W), .STEP_SH(STEP_SH),
      .MIN_UNITS(MINS[i]), .RESET_UNITS(RESETS[i])
    ) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(!port_en),
      .field(fields[i]), .bit_times(thr[i])
    );
  end

  assign gap_bt   = thr[0];
  assign blind_bt = thr[1];

  gap_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(port_en), .tick(bit_tick), .crs(crs),
    .gap_bt(gap_bt), .blind_bt(blind_bt), .cnt(cnt), .zone(zone)
  );

  assign tx_ok = tx_req && (zone == ZONE_DONE);

  // the counter never runs past the captured gap
  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= gap_bt));

  // thresholds frozen while the port stays enabled
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && $past(port_en)) |-> ($stable(gap_bt) && $stable(blind_bt)));

  // permission needs a request and an enabled port
  assert_ok_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |-> (tx_req && port_en));

  // clamped minimum for both thresholds
  assert_min_threshold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_bt >= CNT_W'(GAP_MIN << STEP_SH)) && (blind_bt >= CNT_W'(BLIND_MIN << STEP_SH)));
endmodule

// File: tb/gap_defer_timer_tb.sv
module gap_defer_timer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, port_en, bit_tick, crs, tx_req, tx_ok;
  logic [4:0] cfg_gap, cfg_blind;

  int vectors = 0;
  int errors  = 0;
  string cur  = "R1";
  int m_cnt, m_gap, m_blind;

  gap_defer_timer u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .bit_tick(bit_tick),
    .crs(crs), .tx_req(tx_req), .cfg_gap(cfg_gap), .cfg_blind(cfg_blind),
    .tx_ok(tx_ok)
  );

  // behavioural reference: thresholds in bit-times, plain integer count
  always @(posedge clk) begin : model
    int nc;
    if (!rst_n) begin
      m_cnt = 0; m_gap = 96; m_blind = 64;
    end else begin
      if (!port_en) nc = 0;
      else if (crs && (m_cnt < m_blind || m_cnt == m_gap)) nc = 0;
      else if (bit_tick && m_cnt < m_gap) nc = m_cnt + 1;
      else nc = m_cnt;
      if (!port_en) begin
        m_gap   = ((cfg_gap   < 3) ? 3 : int'(cfg_gap))   * 4;
        m_blind = ((cfg_blind < 3) ? 3 : int'(cfg_blind)) * 4;
      end
      m_cnt = nc;
    end
  end

  task automatic cyc();
    logic e;
    @(posedge clk); #1;
    e = port_en && tx_req && (m_cnt == m_gap);
    vectors++;
    if (tx_ok !== e) begin
      errors++;
      $display("FAIL %s per-cycle: tx_ok=%0b expected %0b", cur, tx_ok, e);
    end
  endtask

  task automatic cycn(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic chk(logic e, string tag);
    vectors++;
    if (tx_ok !== e) begin
      errors++;
      $display("FAIL %s: tx_ok=%0b expected %0b", tag, tx_ok, e);
    end
  endtask

  task automatic slow_ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; cyc();
      bit_tick = 1'b0; cyc();
    end
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL R1 watchdog: run still going, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; port_en = 1'b1; bit_tick = 1'b1; crs = 1'b0; tx_req = 1'b1;
    cfg_gap = 5'd0; cfg_blind = 5'd0;
    cycn(3);
    chk(1'b0, "R1 reset state");
    rst_n = 1'b1;
    // R1: default 96 bit-time gap, port enabled from reset
    cycn(95); chk(1'b0, "R1 default gap one short");
    cyc();    chk(1'b1, "R1 default gap reached");
    // R11 / R7: request drop and saturation
    cur = "R11"; tx_req = 1'b0; #0; chk(1'b0, "R11 no request same cycle");
    cyc();    chk(1'b0, "R11 no request");
    cur = "R7"; tx_req = 1'b1; cycn(3); chk(1'b1, "R7 saturated at gap");

    // R3 / R8: clamped gap, config change while enabled ignored
    cur = "R3"; port_en = 1'b0; cfg_gap = 5'd1; cfg_blind = 5'd3;
    cyc(); chk(1'b0, "R9 disabled blocks permission");
    port_en = 1'b1; cfg_gap = 5'd31; cfg_blind = 5'd31;
    cur = "R8";
    cycn(11); chk(1'b0, "R3 clamped gap one short");
    cyc();    chk(1'b1, "R3 R8 clamped gap of 12 reached");

    // R4: early carrier restart, gap 40 blinder 20
    cur = "R4"; port_en = 1'b0; cfg_gap = 5'd10; cfg_blind = 5'd5;
    cyc(); port_en = 1'b1;
    cycn(10); crs = 1'b1; cyc(); crs = 1'b0;
    cycn(39); chk(1'b0, "R4 restarted gap one short");
    cyc();    chk(1'b1, "R4 restarted gap reached");

    // R6 then R5
    cur = "R6"; crs = 1'b1; cyc(); chk(1'b0, "R6 carrier on complete gap");
    cycn(2); crs = 1'b0;
    cur = "R5"; cycn(25); crs = 1'b1; cycn(3); crs = 1'b0;
    cycn(11); chk(1'b0, "R5 late carrier ignored one short");
    cyc();    chk(1'b1, "R5 late carrier ignored reached");

    // blinder boundary: 19 restarts, 20 does not
    cur = "R4"; crs = 1'b1; cyc(); crs = 1'b0;
    cycn(19); crs = 1'b1; cyc(); crs = 1'b0;
    cur = "R5"; cycn(20); crs = 1'b1; cyc(); crs = 1'b0;
    cycn(18); chk(1'b0, "R5 boundary at blinder one short");
    cyc();    chk(1'b1, "R5 boundary at blinder reached");

    // R10 / R7: blinder clamp with ticks every other cycle, gap 16
    cur = "R10"; port_en = 1'b0; cfg_gap = 5'd4; cfg_blind = 5'd0;
    cyc(); port_en = 1'b1; bit_tick = 1'b0; crs = 1'b1; cyc(); crs = 1'b0;
    slow_ticks(11); crs = 1'b1; cyc(); crs = 1'b0;
    cur = "R7"; slow_ticks(15); chk(1'b0, "R10 clamped blinder restart one short");
    slow_ticks(1); chk(1'b1, "R10 R7 slow ticks reach gap");

    // R9: disable clears permission and count
    cur = "R9"; port_en = 1'b0; #0; chk(1'b0, "R9 disable same cycle");
    cycn(2); port_en = 1'b1; bit_tick = 1'b1; cyc();
    chk(1'b0, "R9 count cleared by disable");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule